// File: doc/BRIEF.md
# Register-Programmed SPI Master

This block is a SPI master controlled through a small memory-mapped register set. Software sets up a configuration word (enable, clock divisor, clock mode, bit order, chip-select polarity and per-select enables, three-wire option), loads up to nine bytes into a byte buffer, and then writes a command word. The command names a chip select, a total byte count, how many of those bytes are transmitted and whether the chip select remains asserted afterwards.

The engine shifts out the transmit bytes first and keeps clocking for the remaining receive-only bytes. Captured bytes are written back into the same buffer slots, so software reads the results from the addresses it used to load the data. A status word gives a busy flag and the number of bytes stored so far. A sticky chip-select option lets several commands form one frame on the bus, for example a command byte followed by an address phase and then a data phase.

Top module: `spi_reg_master`

## Requirements
- R1: After reset, and whenever the enable bit (config bit 0) is clear, every chip select is inactive, the serial clock rests at its idle level and a command write starts nothing.
- R2: With divisor D in config bits 28:16 (0 acts as 1), each serial clock half-period lasts D clock cycles. A command of T bytes holds busy for exactly D*(2+16*T) cycles after the write edge: one setup half-period, 16 half-periods per byte and one hold half-period.
- R3: The clock phase is config bit 11 and the clock polarity is bit 1 XOR bit 11. The clock idles at the polarity level. With phase 0 data is sampled on the leading edge and changes on the trailing edge. With phase 1 data changes on the leading edge and is sampled on the trailing edge.
- R4: Config bit 4 selects LSB-first order within each byte. When it is clear, bytes are sent and received MSB first.
- R5: Command bits 4:0 give the total count T and bits 12:8 the transmit count N. Bytes 0..N-1 are sent from the buffer and later bytes send zeros. In four-wire mode every byte received overwrites its buffer slot, and slots at T and above are left unchanged.
- R6: Command bits 21:20 select one chip select. It is active only if its enable bit (config bit 12+index) is set. Config bit 7 makes the chip selects active-high. At most one select is active at a time.
- R7: With command bit 16 set, the chip select stays active after the last byte. With it clear, the chip select is released once the hold half-period ends.
- R8: Status bit 0 is busy and status bits 12:8 count the bytes stored by the current command. The count is cleared by each accepted command.
- R9: A command with total count zero leaves busy low, does not move the serial clock and leaves the chip-select state unchanged.
- R10: While busy, writes to the config, data and command registers are ignored.
- R11: In three-wire mode (config bit 3), the data output is enabled only for transmit bytes. Receive bytes are sampled from the shared pin and stored, transmit-byte slots keep their contents, and the stored count is T-N.
- R12: Data byte i is at address 0x80+8*i and only the low 8 bits are used. A total count above 9 acts as 9, and a transmit count above the total acts as the total.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | AW (8) | Register byte address |
| bus_wdata | input | DW (32) | Register write data |
| bus_rdata | output | DW (32) | Register read data, combinational on bus_addr |
| spi_sclk | output | 1 | Serial clock |
| spi_sdo | output | 1 | Serial data out |
| spi_sdo_en | output | 1 | Output enable for the data pad |
| spi_sdi | input | 1 | Serial data in (the shared pad in three-wire mode) |
| spi_cs | output | NUM_CS (4) | Chip selects, polarity from config |

## Verification
Each command result is due at a cycle that can be computed in advance. The command takes effect on the write edge, and busy must still read high exactly D*(2+16*T)-1 cycles after that edge and low one cycle later. The bench counts falling edges from the write to reach both of those points, and checks the chip select during busy and after release at the same points. A bench slave samples and drives on the edges that the configured phase calls for, so buffer, count and slave-side bytes are compared only after busy drops. Ignored writes and zero-length commands are checked on the status word and the chip-select pins in the cycle right after the write.

// File: rtl/spi_rm_pkg.sv
package spi_rm_pkg;

   localparam int unsigned OFS_CFG  = 'h00;
   localparam int unsigned OFS_STS  = 'h08;
   localparam int unsigned OFS_CMD  = 'h10;
   localparam int unsigned OFS_DAT0 = 'h80;
   localparam int unsigned OFS_STEP = 8;

   localparam int unsigned CLKDIV_W = 13;
   localparam int unsigned CNT_W    = 5;

   typedef struct packed {
      logic                en;
      logic                mode_xor;
      logic                three_wire;
      logic                lsb_first;
      logic                cs_high;
      logic                phase;
      logic [3:0]          cs_ena;
      logic [CLKDIV_W-1:0] div;
   } cfg_t;

   typedef enum logic [1:0] {ST_IDLE, ST_SETUP, ST_BIT, ST_HOLD} seq_st_e;

endpackage

// File: rtl/spi_rm_regs.sv
module spi_rm_regs
   import spi_rm_pkg::*;
#(
   parameter int unsigned MAX_BYTES = 9,
   parameter int unsigned AW        = 8,
   parameter int unsigned DW        = 32
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      bus_wr,
   input  logic [AW-1:0]             bus_addr,
   input  logic [DW-1:0]             bus_wdata,
   output logic [DW-1:0]             bus_rdata,
   input  logic                      busy,
   input  logic [CNT_W-1:0]          rx_cnt,
   input  logic                      rx_we,
   input  logic [CNT_W-1:0]          rx_idx,
   input  logic [7:0]                rx_byte,
   output cfg_t                      cfg,
   output logic                      start,
   output logic [CNT_W-1:0]          cmd_tot,
   output logic [CNT_W-1:0]          cmd_txn,
   output logic                      cmd_leave,
   output logic [1:0]                cmd_cs,
   output logic [MAX_BYTES-1:0][7:0] buf_q
);

   localparam logic [CNT_W-1:0] MAXB = CNT_W'(MAX_BYTES);

   logic wr_ok;
   logic [CNT_W-1:0] raw_tot, raw_txn;
   logic unused_wdata_bits;

   assign wr_ok = bus_wr && !busy;
   assign unused_wdata_bits = ^{bus_wdata[DW-1:29], bus_wdata[6:5]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg <= '0;
      end else if (wr_ok && bus_addr == AW'(OFS_CFG)) begin
         cfg.en         <= bus_wdata[0];
         cfg.mode_xor   <= bus_wdata[1];
         cfg.three_wire <= bus_wdata[3];
         cfg.lsb_first  <= bus_wdata[4];
         cfg.cs_high    <= bus_wdata[7];
         cfg.phase      <= bus_wdata[11];
         cfg.cs_ena     <= bus_wdata[15:12];
         cfg.div        <= bus_wdata[16 +: CLKDIV_W];
      end
   end

   generate
      for (genvar g = 0; g < MAX_BYTES; g++) begin : g_slot
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               buf_q[g] <= '0;
            else if (rx_we && rx_idx == CNT_W'(g))
               buf_q[g] <= rx_byte;
            else if (wr_ok && bus_addr == AW'(OFS_DAT0 + OFS_STEP * g))
               buf_q[g] <= bus_wdata[7:0];
         end
      end
   endgenerate

   // command decode with clamping of out-of-range counts
   assign raw_tot   = bus_wdata[4:0];
   assign raw_txn   = bus_wdata[12:8];
   assign cmd_tot   = (raw_tot > MAXB) ? MAXB : raw_tot;
   assign cmd_txn   = (raw_txn > cmd_tot) ? cmd_tot : raw_txn;
   assign cmd_leave = bus_wdata[16];
   assign cmd_cs    = bus_wdata[21:20];
   assign start     = wr_ok && cfg.en && bus_addr == AW'(OFS_CMD);

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == AW'(OFS_CFG)) begin
         bus_rdata[0]                = cfg.en;
         bus_rdata[1]                = cfg.mode_xor;
         bus_rdata[3]                = cfg.three_wire;
         bus_rdata[4]                = cfg.lsb_first;
         bus_rdata[7]                = cfg.cs_high;
         bus_rdata[11]               = cfg.phase;
         bus_rdata[15:12]            = cfg.cs_ena;
         bus_rdata[16 +: CLKDIV_W]   = cfg.div;
      end else if (bus_addr == AW'(OFS_STS)) begin
         bus_rdata[0]          = busy;
         bus_rdata[8 +: CNT_W] = rx_cnt;
      end
      for (int i = 0; i < MAX_BYTES; i++)
         if (bus_addr == AW'(OFS_DAT0 + OFS_STEP * i))
            bus_rdata[7:0] = buf_q[i];
   end

   AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(cfg)) else $error("cfg changed while busy"); // R10

endmodule

// File: rtl/spi_rm_clkdiv.sv
module spi_rm_clkdiv #(
   parameter int unsigned DIV_W = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);

   logic [DIV_W-1:0] lim, cnt;

   assign lim  = (div == '0) ? DIV_W'(1) : div;
   assign tick = run && (cnt == lim - DIV_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt <= '0;
      else if (!run || tick) cnt <= '0;
      else                   cnt <= cnt + DIV_W'(1);
   end

   AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (cnt < lim)) else $error("divider count out of range"); // R2

endmodule

// File: rtl/spi_rm_seq.sv
module spi_rm_seq
   import spi_rm_pkg::*;
#(
   parameter int unsigned MAX_BYTES = 9,
   parameter int unsigned NUM_CS    = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  cfg_t                      cfg,
   input  logic                      start,
   input  logic [CNT_W-1:0]          tot,
   input  logic [CNT_W-1:0]          txn,
   input  logic                      leave,
   input  logic [1:0]                csid,
   input  logic                      tick,
   input  logic [MAX_BYTES-1:0][7:0] buf_q,
   input  logic                      sdi,
   output logic                      busy,
   output logic                      sclk,
   output logic                      sdo,
   output logic                      sdo_en,
   output logic [NUM_CS-1:0]         cs_o,
   output logic [CNT_W-1:0]          rx_cnt,
   output logic                      rx_we,
   output logic [CNT_W-1:0]          rx_idx,
   output logic [7:0]                rx_byte
);

   seq_st_e          st;
   logic             half, cs_hold, leave_q, sdo_q, oe_q;
   logic [2:0]       bit_idx, bsel;
   logic [1:0]       cs_q;
   logic [CNT_W-1:0] byte_idx, tot_q, txn_q, rx_cnt_q;
   logic [7:0]       rx_sh, sdi_sh, tx_byte;
   logic             cpha, cpol, in_bit, txing, cur_bit, store, byte_end;
   logic [NUM_CS-1:0] cs_act;
   logic             unused_cfg_bits;

   assign unused_cfg_bits = ^{cfg.div, cfg.cs_ena};

   assign cpha   = cfg.phase;
   assign cpol   = cfg.mode_xor ^ cfg.phase;
   assign busy   = (st != ST_IDLE);
   assign in_bit = (st == ST_BIT);
   assign txing  = in_bit && (byte_idx < txn_q);
   assign sclk   = cpol ^ (in_bit & half);

   always_comb begin
      tx_byte = '0;
      for (int i = 0; i < MAX_BYTES; i++)
         if (byte_idx == CNT_W'(i)) tx_byte = buf_q[i];
   end

   assign bsel    = cfg.lsb_first ? bit_idx : (3'd7 - bit_idx);
   assign cur_bit = tx_byte[bsel];
   assign sdi_sh  = cfg.lsb_first ? {sdi, rx_sh[7:1]} : {rx_sh[6:0], sdi};

   // phase 0: output follows the bit counter, changing at the trailing edge
   // phase 1: output is registered at the leading edge
   assign sdo    = cpha ? sdo_q : (txing & cur_bit);
   assign sdo_en = !cfg.three_wire ? cfg.en : (cpha ? oe_q : txing);

   assign store    = !cfg.three_wire || (byte_idx >= txn_q);
   assign byte_end = in_bit && tick && half && (bit_idx == 3'd7);
   assign rx_we    = byte_end && store;
   assign rx_idx   = byte_idx;
   assign rx_byte  = cpha ? sdi_sh : rx_sh;
   assign rx_cnt   = rx_cnt_q;

   generate
      for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
         assign cs_act[g] = cfg.en && cs_hold && (cs_q == 2'(g)) && cfg.cs_ena[g];
      end
   endgenerate
   assign cs_o = cfg.cs_high ? cs_act : ~cs_act;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= ST_IDLE;  half <= 1'b0;  bit_idx <= '0;  byte_idx <= '0;
         tot_q <= '0;  txn_q <= '0;  leave_q <= 1'b0;  cs_q <= '0;
         cs_hold <= 1'b0;  rx_sh <= '0;  sdo_q <= 1'b0;  oe_q <= 1'b0;
         rx_cnt_q <= '0;
      end else begin
         unique case (st)
            ST_IDLE: begin
               if (!cfg.en) cs_hold <= 1'b0;
               if (start) begin
                  rx_cnt_q <= '0;
                  if (tot != '0) begin
                     st <= ST_SETUP;  tot_q <= tot;  txn_q <= txn;
                     leave_q <= leave;  cs_q <= csid;  cs_hold <= 1'b1;
                     half <= 1'b0;  bit_idx <= '0;  byte_idx <= '0;
                     sdo_q <= 1'b0;  oe_q <= 1'b0;
                  end
               end
            end
            ST_SETUP: if (tick) st <= ST_BIT;
            ST_BIT: if (tick) begin
               if (!half) begin
                  half <= 1'b1;
                  if (cpha) begin
                     sdo_q <= txing & cur_bit;
                     oe_q  <= txing;
                  end else begin
                     rx_sh <= sdi_sh;
                  end
               end else begin
                  half <= 1'b0;
                  if (cpha) rx_sh <= sdi_sh;
                  if (bit_idx == 3'd7) begin
                     bit_idx <= '0;
                     if (store) rx_cnt_q <= rx_cnt_q + CNT_W'(1);
                     if (byte_idx == tot_q - CNT_W'(1)) st <= ST_HOLD;
                     else byte_idx <= byte_idx + CNT_W'(1);
                  end else begin
                     bit_idx <= bit_idx + 3'd1;
                  end
               end
            end
            ST_HOLD: if (tick) begin
               st <= ST_IDLE;  cs_hold <= leave_q;  oe_q <= 1'b0;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(cs_act)) else $error("more than one chip select"); // R6
   AST_DISABLED_CS: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg.en |-> (cs_o == (cfg.cs_high ? '0 : '1))) else $error("cs active while off"); // R1
   AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (start && tot != '0) |=> busy) else $error("command did not start"); // R8
   AST_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (start && tot == '0) |=> !busy) else $error("empty command went busy"); // R9
   AST_RXCNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      rx_cnt_q <= tot_q) else $error("stored count beyond total"); // R8
   AST_CS_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> cs_hold) else $error("cs dropped mid transfer"); // R7
   AST_3W_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg.three_wire && in_bit && byte_idx > txn_q) |-> !sdo_en) else $error("pad driven in rx"); // R11

endmodule

// File: rtl/spi_reg_master.sv
module spi_reg_master
   import spi_rm_pkg::*;
#(
   parameter int unsigned MAX_BYTES = 9,
   parameter int unsigned NUM_CS    = 4,
   parameter int unsigned AW        = 8,
   parameter int unsigned DW        = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [AW-1:0]     bus_addr,
   input  logic [DW-1:0]     bus_wdata,
   output logic [DW-1:0]     bus_rdata,
   output logic              spi_sclk,
   output logic              spi_sdo,
   output logic              spi_sdo_en,
   input  logic              spi_sdi,
   output logic [NUM_CS-1:0] spi_cs
);

   localparam int unsigned LAST_ADDR = OFS_DAT0 + OFS_STEP * (MAX_BYTES - 1);

   generate
      if (MAX_BYTES < 1 || MAX_BYTES > 31) begin : g_bad_bytes
         $error("MAX_BYTES must be 1..31");
      end
      if (NUM_CS < 1 || NUM_CS > 4) begin : g_bad_cs
         $error("NUM_CS must be 1..4");
      end
      if (DW < 29) begin : g_bad_dw
         $error("DW must hold the divisor field");
      end
      if (LAST_ADDR >= (1 << AW)) begin : g_bad_aw
         $error("AW too narrow for the data slots");
      end
   endgenerate

   cfg_t                      cfg;
   logic                      start, busy, tick, leave, rx_we;
   logic [CNT_W-1:0]          tot, txn, rx_cnt, rx_idx;
   logic [1:0]                csid;
   logic [7:0]                rx_byte;
   logic [MAX_BYTES-1:0][7:0] buf_q;

   spi_rm_regs #(.MAX_BYTES(MAX_BYTES), .AW(AW), .DW(DW)) u_regs (
      .clk, .rst_n, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata,
      .busy, .rx_cnt, .rx_we, .rx_idx, .rx_byte,
      .cfg, .start, .cmd_tot(tot), .cmd_txn(txn), .cmd_leave(leave),
      .cmd_cs(csid), .buf_q
   );

   spi_rm_clkdiv #(.DIV_W(CLKDIV_W)) u_div (
      .clk, .rst_n, .run(busy), .div(cfg.div), .tick
   );

   spi_rm_seq #(.MAX_BYTES(MAX_BYTES), .NUM_CS(NUM_CS)) u_seq (
      .clk, .rst_n, .cfg, .start, .tot, .txn, .leave, .csid, .tick, .buf_q,
      .sdi(spi_sdi), .busy, .sclk(spi_sclk), .sdo(spi_sdo), .sdo_en(spi_sdo_en),
      .cs_o(spi_cs), .rx_cnt, .rx_we, .rx_idx, .rx_byte
   );

endmodule

// File: tb/tb_spi_reg_master.sv
module tb_spi_reg_master;
   localparam int CLK_P = 10;

   logic clk = 0, rst_n = 0;
   logic bus_wr = 0;
   logic [7:0] bus_addr = 0;
   logic [31:0] bus_wdata = 0, bus_rdata;
   logic spi_sclk, spi_sdo, spi_sdo_en, spi_sdi;
   logic [3:0] spi_cs;

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   logic [7:0] slv_tx [9];
   logic [7:0] slv_rx [9];
   logic [7:0] tx_pat [9];
   int slv_k = 0;
   bit slv_armed = 0, b_cpol = 0, b_cpha = 0, b_lsb = 0, b_tw = 0;
   logic slv_bit;

   spi_reg_master dut (.clk, .rst_n, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata,
      .spi_sclk, .spi_sdo, .spi_sdo_en, .spi_sdi, .spi_cs);

   always #(CLK_P/2) clk = ~clk;

   always_comb slv_bit = (slv_k < 72) ? slv_tx[slv_k/8][b_lsb ? (slv_k%8) : (7-slv_k%8)] : 1'b0;
   assign spi_sdi = (b_tw && spi_sdo_en) ? spi_sdo : slv_bit;

   // bench slave: samples on the edge the configured phase calls for
   always @(spi_sclk) begin
      if (slv_armed && slv_k < 72 && !$isunknown(spi_sclk)) begin
         if ((spi_sclk != b_cpol) == !b_cpha) begin
            slv_rx[slv_k/8][b_lsb ? (slv_k%8) : (7-slv_k%8)] = spi_sdo;
            slv_k++;
         end
      end
   end

   task automatic chk(input string msg, input longint act, input longint exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s act=%0h exp=%0h", msg, act, exp);
      end
   endtask

   task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
      @(negedge clk); bus_wr = 0;
   endtask

   task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
      bus_addr = a; #1; d = bus_rdata;
   endtask

   function automatic logic [31:0] cfg_word(bit en, bit cpol, bit cpha, bit tw, bit lsb,
                                            bit cshi, logic [3:0] ena, int div);
      return {3'b0, 13'(div), ena, cpha, 3'b0, cshi, 2'b0, lsb, tw, 1'b0, cpha ^ cpol, en};
   endfunction

   function automatic logic [3:0] cs_pat(bit on, int cs, logic [3:0] ena, bit cshi);
      logic [3:0] act = on ? ((4'b1 << cs) & ena) : 4'b0;
      return cshi ? act : ~act;
   endfunction

   task automatic do_xfer(input string tag, input bit cpol, cpha, lsb, tw, cshi,
                          input logic [3:0] ena, input int div, tot_raw, txn_raw,
                          input bit leave, input int cs, input int seed);
      int tot, txn, d, n, exp_cnt;
      logic [31:0] r;
      logic [7:0] exp_b;
      tot = (tot_raw > 9) ? 9 : tot_raw;
      txn = (txn_raw > tot) ? tot : txn_raw;
      d = (div == 0) ? 1 : div;
      n = d * (2 + 16 * tot);
      bus_write(8'h00, cfg_word(1, cpol, cpha, tw, lsb, cshi, ena, div));
      for (int i = 0; i < 9; i++) begin
         tx_pat[i] = 8'(seed * 29 + i * 53 + 7);
         slv_tx[i] = 8'(seed * 71 + i * 19 + 'h5A);
         slv_rx[i] = 8'h00;
         bus_write(8'(8'h80 + 8 * i), {24'hFFFF_FF, tx_pat[i]});
      end
      b_cpol = cpol; b_cpha = cpha; b_lsb = lsb; b_tw = tw; slv_k = 0; slv_armed = 1;
      bus_write(8'h10, (cs << 20) | (int'(leave) << 16) | (txn_raw << 8) | tot_raw);
      repeat (n - 1) @(negedge clk);
      bus_read(8'h08, r);
      chk($sformatf("%s R2 busy still high at cycle %0d", tag, n - 1), r[0], 1);
      chk($sformatf("%s R6 cs during transfer", tag), spi_cs, cs_pat(1, cs, ena, cshi));
      @(negedge clk);
      bus_read(8'h08, r);
      chk($sformatf("%s R2 busy low at cycle %0d", tag, n), r[0], 0);
      exp_cnt = tw ? (tot - txn) : tot;
      chk($sformatf("%s R8 stored count", tag), r[12:8], exp_cnt);
      chk($sformatf("%s R7 cs after end", tag), spi_cs, cs_pat(leave, cs, ena, cshi));
      chk($sformatf("%s R3 sclk idle level", tag), spi_sclk, cpol);
      slv_armed = 0;
      for (int i = 0; i < 9; i++) begin
         bus_read(8'(8'h80 + 8 * i), r);
         if (i >= tot) exp_b = tx_pat[i];
         else if (tw && i < txn) exp_b = tx_pat[i];
         else exp_b = slv_tx[i];
         chk($sformatf("%s R5 R4 buffer[%0d]", tag, i), r, {24'h0, exp_b});
      end
      for (int i = 0; i < tot; i++) begin
         if (i < txn)
            chk($sformatf("%s R5 R3 slave got tx byte %0d", tag, i), slv_rx[i], tx_pat[i]);
         else if (!tw)
            chk($sformatf("%s R5 slave got zero fill %0d", tag, i), slv_rx[i], 0);
      end
   endtask

   task automatic t_reset();
      logic [31:0] r;
      bus_read(8'h08, r);
      chk("R1 R8 status after reset", r, 0);
      bus_read(8'h00, r);
      chk("R1 config after reset", r, 0);
      chk("R1 cs after reset", spi_cs, 4'hF);
      chk("R1 sclk after reset", spi_sclk, 0);
   endtask

   task automatic t_modes();
      do_xfer("mode0", 0, 0, 0, 0, 0, 4'hF, 2, 5, 3, 0, 0, 1);
      do_xfer("mode3 lsb R4", 1, 1, 1, 0, 0, 4'hF, 1, 4, 2, 0, 1, 2);
      do_xfer("mode1", 0, 1, 0, 0, 0, 4'hF, 3, 2, 1, 0, 3, 3);
      do_xfer("mode2 lsb R4", 1, 0, 1, 0, 0, 4'hF, 0, 3, 3, 0, 2, 4);
   endtask

   task automatic t_leave();
      logic [31:0] r;
      do_xfer("R7 leave set", 0, 0, 0, 0, 0, 4'hF, 1, 2, 1, 1, 2, 5);
      bus_write(8'h10, (2 << 20) | 0);
      bus_read(8'h08, r);
      chk("R9 zero count not busy", r[0], 0);
      chk("R9 zero count count cleared", r[12:8], 0);
      chk("R9 zero count cs unchanged", spi_cs, 4'b1011);
      do_xfer("R7 leave clear", 0, 0, 0, 0, 0, 4'hF, 1, 1, 1, 0, 2, 6);
      do_xfer("R7 leave again", 1, 1, 0, 0, 0, 4'hF, 1, 1, 0, 1, 1, 7);
      bus_write(8'h00, cfg_word(0, 1, 1, 0, 0, 0, 4'hF, 1));
      chk("R1 disable drops held cs", spi_cs, 4'hF);
   endtask

   task automatic t_busy_ignore();
      logic [31:0] r, c1;
      c1 = cfg_word(1, 0, 0, 0, 0, 0, 4'hF, 4);
      bus_write(8'h00, c1);
      bus_write(8'hC0, 32'h11);
      bus_write(8'h10, 3);
      bus_write(8'h00, cfg_word(1, 1, 1, 1, 1, 1, 4'h1, 9));
      bus_write(8'hC0, 32'h77);
      bus_write(8'h10, 1);
      for (int k = 0; k < 2000; k++) begin
         bus_read(8'h08, r);
         if (!r[0]) break;
         @(negedge clk);
      end
      @(negedge clk);
      bus_read(8'h08, r);
      chk("R10 command during busy not started", r[0], 0);
      chk("R10 count from first command", r[12:8], 3);
      bus_read(8'h00, r);
      chk("R10 config write during busy ignored", r, c1);
      bus_read(8'hC0, r);
      chk("R10 data write during busy ignored", r, 32'h11);
   endtask

   task automatic t_disable();
      logic [31:0] r;
      bus_write(8'h00, cfg_word(0, 1, 0, 0, 0, 0, 4'hF, 1));
      chk("R1 sclk idles at polarity while off", spi_sclk, 1);
      bus_write(8'h10, 2);
      bus_read(8'h08, r);
      chk("R1 command ignored while off", r[0], 0);
      chk("R1 cs inactive while off", spi_cs, 4'hF);
      bus_write(8'h00, cfg_word(0, 0, 0, 0, 0, 1, 4'hF, 1));
      chk("R1 R6 active-high cs inactive while off", spi_cs, 4'h0);
   endtask

   task automatic t_cs();
      do_xfer("R6 active-high cs2", 0, 0, 0, 0, 1, 4'hF, 1, 2, 2, 0, 2, 8);
      do_xfer("R6 cs1 not enabled", 0, 0, 0, 0, 0, 4'b0001, 1, 1, 1, 0, 1, 9);
   endtask

   task automatic t_three_wire();
      do_xfer("R11 3w phase0", 0, 0, 0, 1, 0, 4'hF, 2, 4, 2, 0, 0, 10);
      do_xfer("R11 3w phase1", 1, 1, 0, 1, 0, 4'hF, 1, 3, 1, 0, 3, 11);
   endtask

   task automatic t_limits();
      logic [31:0] r;
      do_xfer("R12 nine bytes", 0, 0, 0, 0, 0, 4'hF, 1, 9, 9, 0, 0, 12);
      do_xfer("R12 clamp counts", 0, 1, 1, 0, 0, 4'hF, 1, 15, 20, 0, 0, 13);
      bus_write(8'h98, 32'hABCD1234);
      bus_read(8'h98, r);
      chk("R12 data slot keeps low byte", r, 32'h34);
   endtask

   initial begin
      #(CLK_P * 150000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_modes();
      t_leave();
      t_busy_ignore();
      t_disable();
      t_cs();
      t_three_wire();
      t_limits();
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule